// File: doc/BRIEF.md
# Clock-Enable Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial bus slave that keeps a small bank of byte-wide clock-enable registers. A host changes the bank with sequential block writes and reads it back with block reads. There is no register addressing. Writes always start filling at register 0. Reads always begin with a byte count, followed by the registers in ascending order. Each register bit enables one output clock: 1 lets the clock run, and 0 holds it low and stops it switching. The bank is presented as one flat parallel vector so that downstream clock gating can use it directly.

The bus pins are oversampled by the system clock. SCL and SDA pass through a short synchroniser, and start, stop and SCL edges are detected on the synchronised copies. The slave drives SDA only as an open-drain pull-down enable (`sda_oe`). Write transfers carry two leading bytes after the address. The slave acknowledges both and throws their contents away. Data then loads registers 0, 1, 2 and so on until a stop arrives. Any excess bytes are acknowledged and dropped.

Top module: `clkctl_i2c_regs`

## Requirements
- R1: After synchronous reset, every register holds its default value (0xFF for each byte with default parameters) and `sda_oe` is 0.
- R2: Only the address byte 0xD2 (write) and 0xD3 (read) is acknowledged. Any other address byte gets no ACK. After it, the slave neither drives SDA nor changes a register until the next start condition.
- R3: In a write, the two bytes after the address are acknowledged, and their contents are not stored in any register.
- R4: In a write, the third byte after the address goes to register 0, the next to register 1, and so on. A stop after any complete byte keeps the registers already loaded and leaves the later ones unchanged.
- R5: In a write, data bytes past the last register are acknowledged and discarded. No register changes because of them.
- R6: In a read, the slave sends the byte count 0x06 first, then registers 0 to 5 in order, MSB first. Bytes requested beyond register 5 read as 0xFF, because SDA is released.
- R7: A master NACK during a read makes the slave release SDA and stay silent until the next start. A stop condition also always releases SDA.
- R8: A repeated start in the middle of a transfer aborts that transfer and restarts address decoding.
- R9: The slave changes SDA only after an SCL falling edge, or on a start or stop. The ACK goes low after the falling edge that ends the eighth bit and is released at the next falling edge.
- R10: Register k appears on `reg_q[8k+7:8k]`, and bit n of a register enables clock n of that group (1 = run, 0 = held low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| sda_oe | output | 1 | Pull-down enable for SDA (1 = drive low) |
| reg_q | output | NREG*8 | Register bank, register k at bits [8k+7:8k] |

## Verification
The hardest situations to reach are the ones where the slave must stay quiet or give up partway through. Examples are a non-matching address followed by more bytes, a master NACK in the middle of a read, and a repeated start inside a write. The bench has its own bit-level master that can stop, NACK or restart after any byte. It mixes these directed sequences with random-length writes, from zero data bytes up to past the end of the bank, and with random-length reads. Register contents and SDA are then compared against a bench model.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } bus_st_e;
endpackage

// File: rtl/clkctl_line_sync.sv
module clkctl_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // extra top stage keeps the previous synchronised sample
  logic [SYNC_STAGES:0] scl_p;
  logic [SYNC_STAGES:0] sda_p;
  logic scl_c, scl_l, sda_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_c = scl_p[SYNC_STAGES-1];
  assign scl_l = scl_p[SYNC_STAGES];
  assign sda_s = sda_p[SYNC_STAGES-1];
  assign sda_l = sda_p[SYNC_STAGES];

  assign scl_rise  = scl_c & ~scl_l;
  assign scl_fall  = ~scl_c & scl_l;
  assign start_det = scl_c & scl_l & sda_l & ~sda_s;
  assign stop_det  = scl_c & scl_l & ~sda_l & sda_s;
endmodule

// File: rtl/clkctl_reg_bank.sv
module clkctl_reg_bank #(
  parameter int NREG = 6,
  parameter int AW = 3,
  parameter logic [NREG*8-1:0] RST_VALUE = {NREG{8'hFF}}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] reg_q
);
  logic [7:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[k] <= RST_VALUE[8*k +: 8];
      else if (wr_en && wr_addr == AW'(k)) regs[k] <= wr_data;
    end
    assign reg_q[8*k +: 8] = regs[k];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr == AW'(k)) rd_data = regs[k];
    end
  end
endmodule

// File: rtl/clkctl_bus_ctrl.sv
module clkctl_bus_ctrl
  import clkctl_pkg::*;
#(
  parameter int NREG = 6,
  parameter int AW = 3,
  parameter int CW = 4,
  parameter int SKIP = 2,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe,
  output logic          bus_quiet
);
  localparam logic [CW-1:0] CNT_SKIP = CW'(SKIP);
  localparam logic [CW-1:0] CNT_END  = CW'(SKIP + NREG);
  localparam logic [CW-1:0] CNT_REGS = CW'(NREG);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [7:0]    COUNT_BYTE = 8'(NREG);

  bus_st_e       st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [CW-1:0] cnt;
  logic          is_addr;
  logic          rd_mode;
  logic          got_ack;
  logic [7:0]    tx_byte;

  assign rd_addr   = AW'(cnt - CNT_ONE);
  assign bus_quiet = (st == ST_IDLE) || (st == ST_WAIT);

  always_comb begin
    if (cnt == '0)            tx_byte = COUNT_BYTE;
    else if (cnt <= CNT_REGS) tx_byte = rd_data;
    else                      tx_byte = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      cnt     <= '0;
      is_addr <= 1'b0;
      rd_mode <= 1'b0;
      got_ack <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st      <= ST_RX;
        bitcnt  <= '0;
        cnt     <= '0;
        is_addr <= 1'b1;
        sda_oe  <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (is_addr) begin
                is_addr <= 1'b0;
                if (shreg == WR_ADDR) begin
                  rd_mode <= 1'b0;
                  st      <= ST_ACK;
                  sda_oe  <= 1'b1;
                end else if (shreg == RD_ADDR) begin
                  rd_mode <= 1'b1;
                  st      <= ST_ACK;
                  sda_oe  <= 1'b1;
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                st     <= ST_ACK;
                sda_oe <= 1'b1;
                if (cnt >= CNT_SKIP && cnt < CNT_END) begin
                  wr_en   <= 1'b1;
                  wr_addr <= AW'(cnt - CNT_SKIP);
                  wr_data <= shreg;
                end
                if (cnt != CNT_END) cnt <= cnt + CNT_ONE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_mode) begin
                shreg  <= tx_byte;
                sda_oe <= ~tx_byte[7];
                st     <= ST_TX;
                if (cnt != CNT_END) cnt <= cnt + CNT_ONE;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe  <= 1'b0;
                got_ack <= 1'b0;
                st      <= ST_MACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b1};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_WAIT;
              else       got_ack <= 1'b1;
            end else if (scl_fall && got_ack) begin
              bitcnt <= '0;
              shreg  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              st     <= ST_TX;
              if (cnt != CNT_END) cnt <= cnt + CNT_ONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkctl_i2c_regs.sv
module clkctl_i2c_regs #(
  parameter int NREG = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3,
  parameter logic [NREG*8-1:0] RST_VALUE = {NREG{8'hFF}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] reg_q
);
  localparam int SKIP = 2;
  localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int CW   = $clog2(SKIP + NREG + 1);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en, bus_quiet;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  clkctl_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkctl_bus_ctrl #(
    .NREG(NREG), .AW(AW), .CW(CW), .SKIP(SKIP),
    .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe),
    .bus_quiet(bus_quiet)
  );

  clkctl_reg_bank #(.NREG(NREG), .AW(AW), .RST_VALUE(RST_VALUE)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .reg_q(reg_q)
  );
endmodule

// File: rtl/clkctl_i2c_regs_chk.sv
module clkctl_i2c_regs_chk #(
  parameter int NREG = 6,
  parameter int AW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic [NREG*8-1:0] reg_q,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic              bus_quiet
);
  // R9: SDA drive moves only after an SCL fall, start or stop
  assert_oe_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R4: registers change only as a result of a write strobe
  assert_reg_by_write_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_q) |-> $past(wr_en));

  // R5: no write strobe targets a location past the bank
  assert_waddr_range_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < NREG));

  // R3: one strobe per received byte
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R2: idle or ignoring means SDA is released
  assert_quiet_release_R2: assert property (@(posedge clk) disable iff (rst)
    bus_quiet |-> !sda_oe);

  // R7: a stop always releases SDA
  assert_stop_release_R7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
endmodule

bind clkctl_i2c_regs clkctl_i2c_regs_chk #(.NREG(NREG), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .reg_q(reg_q),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .wr_en(wr_en), .wr_addr(wr_addr), .bus_quiet(bus_quiet)
);

// File: tb/clkctl_i2c_regs_bench.sv
module clkctl_i2c_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 6;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] reg_q;
  wire  sda_line = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] model [NREG];
  logic [7:0] wdat [16];
  int unsigned seed_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkctl_i2c_regs u_clkctl_i2c_regs (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_q(reg_q)
  );

  function automatic logic [7:0] exp_read(input int idx);
    if (idx == 0) return 8'(NREG);
    else if (idx <= NREG) return model[idx-1];
    else return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq; wq;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    end
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; ack = ~sda_line; wq; scl_m = 1'b0; wq;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl_m = 1'b1; wq; b[i] = sda_line; wq; scl_m = 1'b0; wq;
    end
    sda_m = ~mack; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    sda_m = 1'b1;
  endtask

  task automatic check_regs(input string tag);
    for (int k = 0; k < NREG; k++)
      chk(tag, {24'h0, reg_q[8*k +: 8]}, {24'h0, model[k]});
  endtask

  // write body after start: address, two dummies, nd data bytes
  task automatic write_body(input int nd, input int dummies);
    logic ack;
    wbyte(8'hD2, ack);
    chk("R2 write address ack (R9 timing)", {31'h0, ack}, 32'h1);
    for (int i = 0; i < dummies; i++) begin
      wbyte(8'h00 + 8'(i * 8'h5A), ack);
      chk("R3 dummy byte ack", {31'h0, ack}, 32'h1);
    end
    for (int i = 0; i < nd; i++) begin
      wbyte(wdat[i], ack);
      chk(i < NREG ? "R4 data ack" : "R5 excess byte ack", {31'h0, ack}, 32'h1);
      if (i < NREG) model[i] = wdat[i];
    end
  endtask

  task automatic do_write(input int nd);
    bus_start; write_body(nd, 2); bus_stop;
    check_regs("R4 register contents after write (R10 layout)");
  endtask

  task automatic read_body(input int nb, input string tag);
    logic ack;
    logic [7:0] b;
    wbyte(8'hD3, ack);
    chk("R2 read address ack", {31'h0, ack}, 32'h1);
    for (int i = 0; i < nb; i++) begin
      rbyte(i != nb - 1, b);
      chk(tag, {24'h0, b}, {24'h0, exp_read(i)});
    end
  endtask

  task automatic do_read(input int nb);
    bus_start; read_body(nb, "R6 read byte"); bus_stop;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    seed_v = $urandom(32'd7321);
    for (int k = 0; k < NREG; k++) model[k] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check_regs("R1 reset value");
    chk("R1 sda released after reset", {31'h0, sda_oe}, 32'h0);

    // full read of defaults
    do_read(NREG + 1);

    // full write with distinct bytes
    for (int i = 0; i < NREG; i++) wdat[i] = 8'h10 + 8'(i * 17);
    do_write(NREG);
    do_read(NREG + 2);

    // foreign address: no ack, following bytes ignored
    bus_start;
    wbyte(8'hA4, ack);
    chk("R2 foreign address not acked", {31'h0, ack}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      wbyte(8'h00, ack);
      chk("R2 bytes after foreign address not acked", {31'h0, ack}, 32'h0);
    end
    bus_stop;
    check_regs("R2 registers unchanged by foreign address");
    bus_start;
    wbyte(8'hD0, ack);
    chk("R2 near-miss address not acked", {31'h0, ack}, 32'h0);
    bus_stop;

    // dummies only, and stop after the first dummy
    bus_start; write_body(0, 2); bus_stop;
    check_regs("R3 dummy bytes not stored");
    bus_start; write_body(0, 1); bus_stop;
    check_regs("R3 stop after command byte");

    // partial write
    for (int i = 0; i < 3; i++) wdat[i] = 8'hC0 | 8'(i);
    do_write(3);

    // overflow write
    for (int i = 0; i < 10; i++) wdat[i] = 8'h30 + 8'(i);
    do_write(10);
    do_read(NREG + 1);

    // repeated start from a write into a read
    wdat[0] = 8'h5C; wdat[1] = 8'hA3;
    bus_start; write_body(2, 2);
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
    read_body(NREG + 1, "R8 read after repeated start");
    bus_stop;
    check_regs("R8 registers after restart");

    // early NACK in a read
    bus_start;
    wbyte(8'hD3, ack);
    rbyte(1'b1, b);
    chk("R6 count byte", {24'h0, b}, 32'h6);
    rbyte(1'b0, b);
    chk("R6 first register", {24'h0, b}, {24'h0, model[0]});
    wq;
    chk("R7 sda released after nack", {31'h0, sda_oe}, 32'h0);
    for (int i = 0; i < 4 * Q * 9; i++) begin
      @(negedge clk);
      if (sda_oe) begin
        chk("R7 slave silent after nack", 32'h1, 32'h0);
        break;
      end
    end
    bus_stop;
    do_read(NREG + 1);

    // random writes and reads
    for (int it = 0; it < 14; it++) begin
      int nd;
      nd = $urandom_range(0, 9);
      for (int i = 0; i < 16; i++) wdat[i] = 8'($urandom);
      do_write(nd);
      if ($urandom_range(0, 1) == 1) do_read($urandom_range(1, NREG + 3));
    end

    finish_run;
  end
endmodule